// File: doc/BRIEF.md
# Output Pin Override Controller

This block drives a group of output pins, the first of which is an active-low flash write-protect line, from an always-on clock domain. Software changes a pin's level through three registers in a bus clock domain. The enable register picks the pins that are overridden. The value register gives the level asked for on each pin. The permission register holds two bits per pin, one allowing a forced low and one allowing a forced high. An override takes effect only when the permission for the requested polarity is set. Otherwise the pin stays low, so write protection stays asserted.

Register writes land in bus-domain flops and read back at once. A toggle handshake carries a snapshot of all three registers into the always-on domain as one set. That snapshot loads a registered output stage. Writes that arrive while a transfer is in flight are merged into the next transfer and are not lost.

Top module: `pin_force_ctrl`

## Requirements
- R1: After reset, all three registers read 0 and every pin output is 0.
- R2: A write at address 0 (enable, bit i = pin i), 1 (value, bit i = pin i) or 2 (permission, bit 2i = allow low and bit 2i+1 = allow high for pin i) reads back from the next bus cycle. Narrow registers are zero-extended on read. Address 3 reads 0, and writes to it change no register.
- R3: A pin whose enable is 1, whose value is 1 and whose allow-high bit is set drives 1.
- R4: A pin whose enable is 1, whose value is 0 and whose allow-low bit is set drives 0.
- R5: A pin whose enable is 1 but whose permission bit for the requested level is clear drives 0.
- R6: A pin whose enable is 0 drives 0, whatever its value and permission bits are.
- R7: After a single write with no transfer in flight, the pin outputs show the new setting no later than one bus cycle plus three always-on cycles after the write edge.
- R8: Pin outputs are registered in the always-on domain. They change only on the always-on edge that accepts a transfer, and they hold steady while no write happens.
- R9: Clearing and then setting an allowed high override gives a 1-to-0 transition on the pin, then a 0-to-1 transition.
- R10: Writes made in consecutive bus cycles during a transfer are not lost. Once the transfers settle, the pins match the last register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register-side clock |
| rst_bus_n | input | 1 | Synchronous active-low reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 2*NPINS | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 2*NPINS | Read data, combinational from register storage |
| clk_aon | input | 1 | Always-on clock |
| rst_aon_n | input | 1 | Synchronous active-low reset, always-on domain |
| pin_out | output | NPINS | Registered pin levels |

## Verification
A table sets all four pins at once with mixed patterns:
- every pin forced high with high allowed;
- every pin forced low with low allowed;
- each polarity requested with only the other polarity allowed;
- enables cleared while all permissions are set;
- patterns that mix these per pin.

These rows tell apart a correct gating from three faulty ones: gating on the wrong permission bit, ignoring the enable, and mixing up pin indices. Directed sequences then cover the rest:
- a single write timed against its deadline, which separates a correct crossing from one that is too slow;
- a clear-then-set of the enable, which shows the output edges in both directions;
- a burst of back-to-back enable writes, which exposes a crossing that drops updates made while busy;
- writes to the unused address and quiet periods, which show that nothing spurious changes.

// File: rtl/pin_force_pkg.sv
// Shared definitions for the output pin override controller.
// Assumes: register addresses are two bits wide; permission bits are
// stored as pairs, even bit = allow low, odd bit = allow high.
package pin_force_pkg;

    typedef enum logic [1:0] {
        ADDR_ENABLE = 2'd0,
        ADDR_VALUE  = 2'd1,
        ADDR_PERMIT = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    // Level a single pin takes from its override controls.
    function automatic logic pin_level(input logic en, input logic val,
                                       input logic allow_lo, input logic allow_hi);
        logic lvl;
        if (!en)
            lvl = 1'b0;
        else if (val && allow_hi)
            lvl = 1'b1;
        else if (!val && allow_lo)
            lvl = 1'b0;
        else
            lvl = 1'b0;
        return lvl;
    endfunction

endpackage

// File: rtl/pin_force_regs.sv
// Bus-domain register storage with combinational read-back.
// Assumes: one write per cycle; address 3 is unused.
module pin_force_regs
    import pin_force_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [2*NPINS-1:0] wr_data,
    input  logic [1:0]         rd_addr,
    output logic [2*NPINS-1:0] rd_data,
    output logic [NPINS-1:0]   en_q,
    output logic [NPINS-1:0]   val_q,
    output logic [2*NPINS-1:0] perm_q,
    output logic               wr_hit
);
    localparam int DW = 2 * NPINS;

    // A write to a live register asks for a new transfer.
    always_comb begin
        wr_hit = wr_en && (wr_addr != ADDR_SPARE);
    end

    // Register storage updated by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            val_q  <= '0;
            perm_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_ENABLE: en_q   <= wr_data[NPINS-1:0];
                ADDR_VALUE:  val_q  <= wr_data[NPINS-1:0];
                ADDR_PERMIT: perm_q <= wr_data;
                default:     ;
            endcase
        end
    end

    // Read-back multiplexer, independent of the crossing.
    always_comb begin
        case (rd_addr)
            ADDR_ENABLE: rd_data = {{(DW-NPINS){1'b0}}, en_q};
            ADDR_VALUE:  rd_data = {{(DW-NPINS){1'b0}}, val_q};
            ADDR_PERMIT: rd_data = perm_q;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pin_force_launch.sv
// Bus-side half of the toggle handshake: snapshots the register set into a
// hold register and flips a request toggle; waits for the synchronized
// acknowledge before sending again. Writes during a transfer set a pending
// flag so the newest contents follow.
// Assumes: cfg_in is stable-registered in the bus domain.
module pin_force_launch #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [CW-1:0] cfg_in,
    input  logic          ack_tgl,
    output logic          req_tgl,
    output logic [CW-1:0] cfg_hold
);
    logic ack_s1, ack_s2, pending, busy;

    // Two-flop synchronizer for the acknowledge toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= ack_tgl;
            ack_s2 <= ack_s1;
        end
    end

    // A transfer is in flight until the acknowledge matches the request.
    always_comb begin
        busy = req_tgl ^ ack_s2;
    end

    // Launch a snapshot when something is pending and the channel is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            req_tgl  <= 1'b0;
            cfg_hold <= '0;
        end else if (pending && !busy) begin
            cfg_hold <= cfg_in;
            req_tgl  <= ~req_tgl;
            pending  <= wr_hit;
        end else if (wr_hit) begin
            pending  <= 1'b1;
        end
    end

endmodule

// File: rtl/pin_force_land.sv
// Always-on half of the handshake: synchronizes the request toggle, emits a
// one-cycle load pulse on each change and returns the toggle as acknowledge.
// Assumes: the hold register is frozen while a request is unacknowledged.
module pin_force_land (
    input  logic clk,
    input  logic rst_n,
    input  logic req_tgl,
    output logic load,
    output logic ack_tgl
);
    logic s1, s2, s3;

    // Two-flop synchronizer plus one edge-detect stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= req_tgl;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Pulse when the synchronized toggle changes.
    always_comb begin
        load    = s2 ^ s3;
        ack_tgl = s3;
    end

endmodule

// File: rtl/pin_force_select.sv
// Per-pin output registers in the always-on domain; each pin reloads its
// level from the transferred snapshot on a load pulse.
// Assumes: snapshot layout {perm, val, en}, NPINS bits for en and val.
module pin_force_select
    import pin_force_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [4*NPINS-1:0] cfg,
    output logic [NPINS-1:0]   pin_out
);
    localparam int VAL_LSB  = NPINS;
    localparam int PERM_LSB = 2 * NPINS;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Reload this pin's level when a new snapshot arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pin_out[i] <= 1'b0;
            else if (load)
                pin_out[i] <= pin_level(cfg[i], cfg[VAL_LSB+i],
                                        cfg[PERM_LSB+2*i], cfg[PERM_LSB+2*i+1]);
        end
    end

endmodule

// File: rtl/pin_force_ctrl.sv
// Output pin override controller top: bus registers, toggle-handshake
// crossing into the always-on domain, and registered pin selection.
// Assumes: the two resets are each synchronous to their own clock.
module pin_force_ctrl #(
    parameter int NPINS = 4
) (
    input  logic               clk_bus,
    input  logic               rst_bus_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [2*NPINS-1:0] wr_data,
    input  logic [1:0]         rd_addr,
    output logic [2*NPINS-1:0] rd_data,
    input  logic               clk_aon,
    input  logic               rst_aon_n,
    output logic [NPINS-1:0]   pin_out
);
    localparam int CW = 4 * NPINS;

    logic [NPINS-1:0]   en_q, val_q;
    logic [2*NPINS-1:0] perm_q;
    logic               wr_hit, req_tgl, ack_tgl, load;
    logic [CW-1:0]      cfg_hold;

    pin_force_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk_bus), .rst_n(rst_bus_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .en_q(en_q), .val_q(val_q), .perm_q(perm_q), .wr_hit(wr_hit)
    );

    pin_force_launch #(.CW(CW)) u_launch (
        .clk(clk_bus), .rst_n(rst_bus_n), .wr_hit(wr_hit),
        .cfg_in({perm_q, val_q, en_q}), .ack_tgl(ack_tgl),
        .req_tgl(req_tgl), .cfg_hold(cfg_hold)
    );

    pin_force_land u_land (
        .clk(clk_aon), .rst_n(rst_aon_n), .req_tgl(req_tgl),
        .load(load), .ack_tgl(ack_tgl)
    );

    pin_force_select #(.NPINS(NPINS)) u_select (
        .clk(clk_aon), .rst_n(rst_aon_n), .load(load),
        .cfg(cfg_hold), .pin_out(pin_out)
    );

endmodule

// File: rtl/pin_force_ctrl_chk.sv
// Property checker for pin_force_ctrl, attached with bind.
// Assumes: snapshot layout {perm, val, en} as built by the top.
module pin_force_ctrl_chk #(
    parameter int NPINS = 4
) (
    input logic               clk_bus,
    input logic               rst_bus_n,
    input logic               clk_aon,
    input logic               rst_aon_n,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic [2*NPINS-1:0] wr_data,
    input logic [NPINS-1:0]   en_q,
    input logic [NPINS-1:0]   val_q,
    input logic [2*NPINS-1:0] perm_q,
    input logic               req_tgl,
    input logic [4*NPINS-1:0] cfg_hold,
    input logic               load,
    input logic [NPINS-1:0]   pin_out
);
    localparam int VAL_LSB  = NPINS;
    localparam int PERM_LSB = 2 * NPINS;

    // R2: enable write is visible in storage on the next bus cycle.
    assert_enable_readback_R2: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_en && wr_addr == 2'd0) |=> en_q == $past(wr_data[NPINS-1:0]));

    // R2: value write is visible in storage on the next bus cycle.
    assert_value_readback_R2: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_en && wr_addr == 2'd1) |=> val_q == $past(wr_data[NPINS-1:0]));

    // R2: permission write is visible in storage on the next bus cycle.
    assert_permit_readback_R2: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_en && wr_addr == 2'd2) |=> perm_q == $past(wr_data));

    // R10: the snapshot only moves together with a new request.
    assert_hold_moves_with_req_R10: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        !$stable(cfg_hold) |-> !$stable(req_tgl));

    // R10: the snapshot is settled when the always-on side consumes it.
    assert_hold_settled_at_load_R10: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
        load |-> $stable(cfg_hold));

    // R8: pins change only on the edge that accepts a transfer.
    assert_pin_moves_on_load_R8: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
        !$stable(pin_out) |-> $past(load));

    for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
        // R6: a loaded high level needs the pin's enable.
        assert_high_needs_enable_R6: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
            load |=> (!pin_out[i] || $past(cfg_hold[i])));
        // R5: a loaded high level needs value 1 and allow-high.
        assert_high_needs_permit_R5: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
            load |=> (!pin_out[i] || ($past(cfg_hold[VAL_LSB+i]) && $past(cfg_hold[PERM_LSB+2*i+1]))));
        // R3: an allowed enabled high request drives the pin high.
        assert_allowed_high_R3: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
            (load && cfg_hold[i] && cfg_hold[VAL_LSB+i] && cfg_hold[PERM_LSB+2*i+1]) |=> pin_out[i]);
        // R4: an enabled low request drives the pin low.
        assert_requested_low_R4: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
            (load && cfg_hold[i] && !cfg_hold[VAL_LSB+i] && cfg_hold[PERM_LSB+2*i]) |=> !pin_out[i]);
    end

endmodule

bind pin_force_ctrl pin_force_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_aon(clk_aon), .rst_aon_n(rst_aon_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_q(en_q), .val_q(val_q), .perm_q(perm_q),
    .req_tgl(req_tgl), .cfg_hold(cfg_hold), .load(load), .pin_out(pin_out)
);

// File: tb/pin_force_ctrl_test.sv
// Self-checking bench for pin_force_ctrl: table walk, then directed cases.
module pin_force_ctrl_test;
    localparam int NP = 4;

    logic          clk_bus = 1'b0, clk_aon = 1'b0;
    logic          rst_bus_n = 1'b0, rst_aon_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0, rd_addr = '0;
    logic [2*NP-1:0] wr_data = '0, rd_data;
    logic [NP-1:0] pin_out;

    int checks = 0, fails = 0;
    logic done = 1'b0;

    always #4 clk_bus = ~clk_bus;    // 125 MHz
    always #12 clk_aon = ~clk_aon;

    pin_force_ctrl #(.NPINS(NP)) uut (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .clk_aon(clk_aon), .rst_aon_n(rst_aon_n), .pin_out(pin_out)
    );

    typedef struct packed {
        logic [3:0] en;
        logic [3:0] val;
        logic [7:0] perm;
        logic [3:0] exp;
        logic [3:0] req;
    } vec_t;

    // Expected level per pin = en & val & allow-high (odd permission bits).
    localparam vec_t VECS [8] = '{
        '{4'hF, 4'hF, 8'hAA, 4'hF, 4'd3},
        '{4'hF, 4'h0, 8'h55, 4'h0, 4'd4},
        '{4'hF, 4'hF, 8'h55, 4'h0, 4'd5},
        '{4'hF, 4'h0, 8'hAA, 4'h0, 4'd5},
        '{4'h0, 4'hF, 8'hFF, 4'h0, 4'd6},
        '{4'h5, 4'hF, 8'hFF, 4'h5, 4'd6},
        '{4'hF, 4'h6, 8'h8A, 4'h2, 4'd5},
        '{4'hA, 4'hA, 8'hC0, 4'h8, 4'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [2*NP-1:0] d);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [2*NP-1:0] d);
        @(negedge clk_bus);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic aon_wait(input int n);
        repeat (n) @(negedge clk_aon);
    endtask

    initial begin
        logic [2*NP-1:0] rd;
        logic [NP-1:0] seen;
        aon_wait(4);
        // R1: reset state of registers and pins.
        check("R1", {28'd0, pin_out}, 32'h0);
        rst_bus_n = 1'b1; rst_aon_n = 1'b1;
        aon_wait(2);
        for (int a = 0; a < 3; a++) begin
            bus_read(2'(a), rd);
            check("R1", {24'd0, rd}, 32'h0);
        end
        check("R1", {28'd0, pin_out}, 32'h0);

        // Table walk over override patterns (R3..R6).
        for (int k = 0; k < 8; k++) begin
            bus_write(2'd1, {4'h0, VECS[k].val});
            bus_write(2'd2, VECS[k].perm);
            bus_write(2'd0, {4'h0, VECS[k].en});
            aon_wait(14);
            check($sformatf("R%0d row %0d", VECS[k].req, k), {28'd0, pin_out}, {28'd0, VECS[k].exp});
        end

        // R7: single write reaches the pins within the deadline.
        bus_write(2'd1, 8'h0F);
        bus_write(2'd2, 8'hAA);
        bus_write(2'd0, 8'h00);
        aon_wait(14);
        check("R7 before", {28'd0, pin_out}, 32'h0);
        bus_write(2'd0, 8'h0F);
        aon_wait(5);
        check("R7", {28'd0, pin_out}, 32'hF);

        // R9: release then restore gives 1->0 then 0->1.
        bus_write(2'd0, 8'h00);
        aon_wait(5);
        check("R9 fall", {28'd0, pin_out}, 32'h0);
        bus_write(2'd0, 8'h0F);
        aon_wait(5);
        check("R9 rise", {28'd0, pin_out}, 32'hF);

        // R10: back-to-back enable writes; the last one must win.
        @(negedge clk_bus);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h01;
        @(negedge clk_bus); wr_data = 8'h03;
        @(negedge clk_bus); wr_data = 8'h07;
        @(negedge clk_bus); wr_data = 8'h06;
        @(negedge clk_bus); wr_en = 1'b0;
        aon_wait(20);
        check("R10", {28'd0, pin_out}, 32'h6);

        // R8: pins hold while no write happens.
        seen = pin_out;
        for (int t = 0; t < 6; t++) begin
            aon_wait(1);
            check("R8", {28'd0, pin_out}, {28'd0, seen});
        end

        // R2: spare address ignored, live registers read back.
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, rd);
        check("R2 spare", {24'd0, rd}, 32'h0);
        bus_read(2'd0, rd);
        check("R2 enable", {24'd0, rd}, 32'h06);
        bus_read(2'd1, rd);
        check("R2 value", {24'd0, rd}, 32'h0F);
        bus_read(2'd2, rd);
        check("R2 permit", {24'd0, rd}, 32'hAA);
        bus_write(2'd2, 8'h5A);
        bus_read(2'd2, rd);
        check("R2 permit new", {24'd0, rd}, 32'h5A);
        aon_wait(10);
        check("R8 after spare", {28'd0, pin_out}, 32'h2);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #400000;
                fails++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule